// File: doc/BRIEF.md
# USB Suspend and Frame Monitor

This block observes bus activity and start-of-frame events on behalf of a USB device function. It raises five status flags: a suspend request, an end of suspend, a bus reset, a received frame start and a missed frame start. Each flag stays set until software clears it. The block also holds the low-power suspend control bit, drives an internal wake-up line, and pulses a clear request toward the device address and endpoint registers.

Idle time is measured in ticks of a free-running 1 ms frame tick. A bus reset arms the idle check. The check is frozen while the low-power bit is set. After an end of suspend, it stays frozen for a fixed number of resume ticks. Bus activity seen while the low-power bit is set clears that bit in the same cycle, without waiting for a clock edge or for software.

The flag vector uses this layout: bit 0 is the missed frame start, bit 1 is the received frame start, bit 2 is the bus reset, bit 3 is the suspend request and bit 4 is the end of suspend. The clear mask uses the same layout. Defaults are `IDLE_TICKS` = 3 and `RESUME_TICKS` = 2.

Top module: `usb_susp_frame_mon`

## Requirements
- R1: While the check is active, flag bit 3 (suspend request) is set by the `IDLE_TICKS`-th frame tick that arrives with no `act_i` pulse since the last activity. An `act_i` pulse restarts the count. The flag is raised once and is not raised again until new activity.
- R2: After system reset the suspend check is inactive, and no number of ticks sets bit 3 until a bus reset has been seen.
- R3: The idle count is frozen and bit 3 cannot be set while the low-power bit is 1. After an end of suspend, the check stays disabled for `RESUME_TICKS` frame ticks, then restarts from a zero count.
- R4: `act_i` while the low-power bit is 1 sets flag bit 4 (end of suspend). In that same cycle `lp_susp_o` reads 0, and the stored bit is cleared at the next edge.
- R5: `wake_o` is 1 in the cycle of an end of suspend only when `wake_en_i` is 1, and is 0 otherwise.
- R6: `bus_rst_i` sets flag bit 2 and produces a one-cycle `dev_clr_o` pulse in the following cycle. It also arms the suspend check and cancels any resume wait.
- R7: `sof_i` sets flag bit 1.
- R8: A frame tick sets flag bit 0 (missed frame start) when all of the following hold: at least one SOF has been seen since the last bus reset, no SOF arrived during the frame (including the tick cycle itself), and the low-power bit is 0.
- R9: Flags reset to 0 and stay set until software writes 1 to the matching bit of `flag_clr_i`. If a set event and a clear of the same bit arrive in the same cycle, the set wins.
- R10: `lp_set_i` sets the low-power bit, which is visible on `lp_susp_o` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| act_i | input | 1 | Bus activity strobe from the line-state decoder |
| sof_i | input | 1 | Start-of-frame packet received strobe |
| bus_rst_i | input | 1 | USB bus reset received strobe |
| tick_i | input | 1 | Free-running 1 ms frame tick |
| lp_set_i | input | 1 | Software write that sets the low-power bit |
| flag_clr_i | input | 5 | Write-1-to-clear mask for the flags |
| wake_en_i | input | 1 | Wake-up line enable |
| flags_o | output | 5 | Sticky flag vector |
| lp_susp_o | output | 1 | Low-power suspend control bit |
| wake_o | output | 1 | Internal wake-up line |
| dev_clr_o | output | 1 | Clear pulse for device address and endpoint registers |

## Verification
A wrong idle or resume count shows up on flag bit 3 at the tick where it is raised. The flag is set one tick too early or too late, or it is set while suspended, and the error is visible within a few frame ticks. A wrong low-power state shows up on `lp_susp_o` or `wake_o` in the same cycle as the activity strobe. A broken frame-window bit shows up on flag bit 0 at the first tick after a frame with no SOF. The bench compares every output against a behavioural model on every clock, so a divergence is reported in the cycle it first appears.

// File: rtl/usb_sfm_pkg.sv
package usb_sfm_pkg;
    localparam int FLAG_N  = 5;
    localparam int F_MISS  = 0;
    localparam int F_SOF   = 1;
    localparam int F_BRST  = 2;
    localparam int F_SUSP  = 3;
    localparam int F_ESUSP = 4;

    typedef struct packed {
        logic end_susp;
        logic susp_req;
        logic bus_rst;
        logic sof;
        logic miss_sof;
    } sfm_evt_t;

    function automatic logic [FLAG_N-1:0] evt_vec(input sfm_evt_t e);
        return e;
    endfunction
endpackage

// File: rtl/usb_sfm_power.sv
module usb_sfm_power #(
    parameter int RESUME_TICKS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic act_i,
    input  logic tick_i,
    input  logic brst_i,
    input  logic set_lp_i,
    input  logic wake_en_i,
    output logic lp_susp_o,
    output logic wake_o,
    output logic end_susp_o,
    output logic check_active_o,
    output logic resume_done_o
);
    localparam int RW = $clog2(RESUME_TICKS + 1);
    localparam logic [RW-1:0] RLAST = RW'(RESUME_TICKS - 1);

    logic          lp_q, rsm_q, chk_q;
    logic [RW-1:0] rsm_cnt_q;

    assign end_susp_o     = lp_q & act_i;
    assign lp_susp_o      = lp_q & ~act_i;
    assign wake_o         = end_susp_o & wake_en_i;
    assign check_active_o = chk_q & ~lp_q & ~rsm_q;
    assign resume_done_o  = rsm_q & tick_i & ~brst_i & ~end_susp_o
                          & (rsm_cnt_q == RLAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            lp_q <= 1'b0;
        end else if (end_susp_o) begin
            lp_q <= 1'b0;
        end else if (set_lp_i) begin
            lp_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsm_q     <= 1'b0;
            rsm_cnt_q <= '0;
        end else if (brst_i) begin
            rsm_q     <= 1'b0;
            rsm_cnt_q <= '0;
        end else if (end_susp_o) begin
            rsm_q     <= 1'b1;
            rsm_cnt_q <= '0;
        end else if (rsm_q && tick_i) begin
            if (rsm_cnt_q == RLAST) begin
                rsm_q <= 1'b0;
            end else begin
                rsm_cnt_q <= rsm_cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_q <= 1'b0;
        end else if (brst_i) begin
            chk_q <= 1'b1;
        end
    end

    // R4: activity during low-power drops the stored bit at the next edge
    a_r4_end_susp_clears_lp: assert property (@(posedge clk) disable iff (rst)
        lp_q && act_i |=> !lp_q);

    // R3: the check is never active while a resume wait is pending
    a_r3_no_check_in_resume: assert property (@(posedge clk) disable iff (rst)
        end_susp_o && !brst_i |=> !check_active_o);
endmodule

// File: rtl/usb_sfm_idle_timer.sv
module usb_sfm_idle_timer #(
    parameter int IDLE_TICKS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic check_active_i,
    input  logic tick_i,
    input  logic act_i,
    input  logic brst_i,
    input  logic resume_done_i,
    output logic susp_evt_o
);
    localparam int CW = $clog2(IDLE_TICKS + 1);
    localparam logic [CW-1:0] ILAST = CW'(IDLE_TICKS - 1);
    localparam logic [CW-1:0] IMAX  = CW'(IDLE_TICKS);

    logic [CW-1:0] idle_q;

    assign susp_evt_o = check_active_i & tick_i & ~act_i & (idle_q == ILAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_q <= '0;
        end else if (brst_i || act_i || resume_done_i) begin
            idle_q <= '0;
        end else if (check_active_i && tick_i && idle_q < IMAX) begin
            idle_q <= idle_q + 1'b1;
        end
    end

    // R1: a suspend request only on a quiet tick
    a_r1_susp_on_quiet_tick: assert property (@(posedge clk) disable iff (rst)
        susp_evt_o |-> tick_i && !act_i);

    // R3: count frozen while the check is inactive and nothing restarts it
    a_r3_frozen_when_inactive: assert property (@(posedge clk) disable iff (rst)
        !check_active_i && !brst_i && !act_i && !resume_done_i |=> $stable(idle_q));
endmodule

// File: rtl/usb_sfm_frame_chk.sv
module usb_sfm_frame_chk (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic sof_i,
    input  logic brst_i,
    input  logic lp_i,
    output logic miss_evt_o
);
    logic armed_q, seen_q;

    assign miss_evt_o = tick_i & armed_q & ~seen_q & ~sof_i & ~lp_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            seen_q  <= 1'b0;
        end else begin
            if (brst_i)     armed_q <= 1'b0;
            else if (sof_i) armed_q <= 1'b1;
            if (tick_i)     seen_q  <= 1'b0;
            else if (sof_i) seen_q  <= 1'b1;
        end
    end

    // R8: a missed frame start never coincides with a received one
    a_r8_miss_needs_tick: assert property (@(posedge clk) disable iff (rst)
        miss_evt_o |-> tick_i && !sof_i);
endmodule

// File: rtl/usb_sfm_flags.sv
module usb_sfm_flags
    import usb_sfm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [FLAG_N-1:0] set_i,
    input  logic [FLAG_N-1:0] clr_i,
    output logic [FLAG_N-1:0] flags_o
);
    logic [FLAG_N-1:0] flag_q;

    for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) flag_q[i] <= 1'b0;
            else     flag_q[i] <= (flag_q[i] & ~clr_i[i]) | set_i[i];
        end

        // R9: a set flag holds until cleared
        a_r9_flag_sticky: assert property (@(posedge clk) disable iff (rst)
            flag_q[i] && !clr_i[i] |=> flag_q[i]);
        // R9: set wins over clear
        a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
            set_i[i] |=> flag_q[i]);
    end

    assign flags_o = flag_q;
endmodule

// File: rtl/usb_susp_frame_mon.sv
module usb_susp_frame_mon
    import usb_sfm_pkg::*;
#(
    parameter int IDLE_TICKS   = 3,
    parameter int RESUME_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              act_i,
    input  logic              sof_i,
    input  logic              bus_rst_i,
    input  logic              tick_i,
    input  logic              lp_set_i,
    input  logic [FLAG_N-1:0] flag_clr_i,
    input  logic              wake_en_i,
    output logic [FLAG_N-1:0] flags_o,
    output logic              lp_susp_o,
    output logic              wake_o,
    output logic              dev_clr_o
);
    sfm_evt_t evt;
    logic     end_susp, check_active, resume_done, susp_evt, miss_evt;
    logic     dev_clr_q;

    usb_sfm_power #(.RESUME_TICKS(RESUME_TICKS)) u_power (
        .clk(clk), .rst(rst), .act_i(act_i), .tick_i(tick_i),
        .brst_i(bus_rst_i), .set_lp_i(lp_set_i), .wake_en_i(wake_en_i),
        .lp_susp_o(lp_susp_o), .wake_o(wake_o), .end_susp_o(end_susp),
        .check_active_o(check_active), .resume_done_o(resume_done)
    );

    usb_sfm_idle_timer #(.IDLE_TICKS(IDLE_TICKS)) u_idle (
        .clk(clk), .rst(rst), .check_active_i(check_active), .tick_i(tick_i),
        .act_i(act_i), .brst_i(bus_rst_i), .resume_done_i(resume_done),
        .susp_evt_o(susp_evt)
    );

    usb_sfm_frame_chk u_frame (
        .clk(clk), .rst(rst), .tick_i(tick_i), .sof_i(sof_i),
        .brst_i(bus_rst_i), .lp_i(lp_susp_o | end_susp), .miss_evt_o(miss_evt)
    );

    always_comb begin
        evt.end_susp = end_susp;
        evt.susp_req = susp_evt;
        evt.bus_rst  = bus_rst_i;
        evt.sof      = sof_i;
        evt.miss_sof = miss_evt;
    end

    usb_sfm_flags u_flags (
        .clk(clk), .rst(rst), .set_i(evt_vec(evt)), .clr_i(flag_clr_i),
        .flags_o(flags_o)
    );

    always_ff @(posedge clk) begin
        if (rst) dev_clr_q <= 1'b0;
        else     dev_clr_q <= bus_rst_i;
    end
    assign dev_clr_o = dev_clr_q;

    // R6: a bus reset is followed by the register clear pulse
    a_r6_dev_clr_follows: assert property (@(posedge clk) disable iff (rst)
        bus_rst_i |=> dev_clr_o);
    // R5: no wake without the enable
    a_r5_wake_needs_en: assert property (@(posedge clk) disable iff (rst)
        !wake_en_i |-> !wake_o);
endmodule

// File: tb/usb_susp_frame_mon_tb.sv
module usb_susp_frame_mon_tb_top;
    localparam int IDLE = 3;
    localparam int RES  = 2;

    logic       clk = 0, rst = 1;
    logic       act = 0, sof = 0, brst = 0, tick = 0, lpset = 0, wen = 0;
    logic [4:0] clr = 0;
    logic [4:0] flags;
    logic       lp_o, wake_o, devclr_o;

    int n_checks = 0, n_fail = 0;

    // reference model state
    int m_chk = 0, m_lp = 0, m_rsm = 0, m_rcnt = 0, m_idle = 0;
    int m_seen = 0, m_armed = 0, m_devclr = 0;
    int m_flags[5] = '{0, 0, 0, 0, 0};
    string tagmap[5] = '{"R8", "R7", "R6", "R1", "R4"};
    logic last_wake = 0, last_lp = 0;

    always #2 clk = ~clk;

    usb_susp_frame_mon dut_i (
        .clk(clk), .rst(rst), .act_i(act), .sof_i(sof), .bus_rst_i(brst),
        .tick_i(tick), .lp_set_i(lpset), .flag_clr_i(clr), .wake_en_i(wen),
        .flags_o(flags), .lp_susp_o(lp_o), .wake_o(wake_o), .dev_clr_o(devclr_o)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic model_update();
        int set[5];
        int esusp, active, susp;
        for (int i = 0; i < 5; i++) set[i] = 0;
        esusp  = (m_lp != 0) && act;
        active = m_chk && !m_lp && !m_rsm;
        susp   = active && tick && !act && (m_idle == IDLE - 1);
        set[2] = brst;
        set[1] = sof;
        set[0] = tick && m_armed && !m_seen && !sof && !m_lp;
        set[3] = susp;
        set[4] = esusp;
        m_devclr = brst;
        if (brst) m_armed = 0; else if (sof) m_armed = 1;
        if (tick) m_seen = 0; else if (sof) m_seen = 1;
        if (brst || act) m_idle = 0;
        else if (active && tick && m_idle < IDLE) m_idle++;
        if (brst) begin m_rsm = 0; m_rcnt = 0; end
        else if (esusp) begin m_rsm = 1; m_rcnt = 0; end
        else if (m_rsm && tick) begin
            if (m_rcnt == RES - 1) begin m_rsm = 0; m_idle = 0; end
            else m_rcnt++;
        end
        if (esusp) m_lp = 0; else if (lpset) m_lp = 1;
        if (brst) m_chk = 1;
        for (int i = 0; i < 5; i++)
            m_flags[i] = (m_flags[i] && !clr[i]) || set[i];
    endtask

    task automatic step(input logic a, input logic s, input logic b, input logic t,
                        input logic l, input logic [4:0] c);
        @(negedge clk);
        for (int i = 0; i < 5; i++) check(tagmap[i], flags[i], m_flags[i]);
        check("R6", devclr_o, m_devclr);
        act = a; sof = s; brst = b; tick = t; lpset = l; clr = c;
        #1;
        last_wake = wake_o;
        last_lp   = lp_o;
        check("R10", lp_o, m_lp && !a);
        check("R5", wake_o, m_lp && a && wen);
        @(posedge clk);
        model_update();
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
    endtask
    task automatic ftick();
        step(0, 0, 0, 1, 0, 0);
        idle(2);
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: got 0 expected 1 (run finished)");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        check("R9 reset flags", flags, 0);
        check("R10 reset lp", lp_o, 0);
        check("R5 reset wake", wake_o, 0);
        check("R6 reset devclr", devclr_o, 0);

        // R2: no suspend request before any bus reset
        for (int i = 0; i < 5; i++) ftick();
        check("R2 no check before bus reset", flags[3], 0);

        // R6: bus reset
        step(0, 0, 1, 0, 0, 0);
        check("R6 reset flag", flags[2], 1);
        check("R6 dev clear pulse", devclr_o, 1);
        idle(1);
        check("R6 pulse one cycle", devclr_o, 0);

        // R1: activity restarts idle count
        ftick(); ftick();
        step(1, 0, 0, 0, 0, 0);
        ftick(); ftick();
        check("R1 restart by activity", flags[3], 0);
        ftick();
        check("R1 suspend after idle", flags[3], 1);

        // R9: clear and set-wins
        step(0, 0, 0, 0, 0, 5'h1f);
        check("R9 cleared", flags, 0);
        step(0, 1, 0, 0, 0, 5'h02);
        check("R9 set wins over clear", flags[1], 1);
        check("R7 sof flag", flags[1], 1);
        step(0, 0, 0, 0, 0, 5'h1f);

        // R8: missed SOF
        ftick();
        check("R8 no miss with sof in frame", flags[0], 0);
        step(0, 1, 0, 0, 0, 0);
        ftick();
        check("R8 still no miss", flags[0], 0);
        ftick();
        check("R8 miss flagged", flags[0], 1);
        check("R1 no repeat without activity", flags[3], 0);

        // R10/R3: low-power freezes the check
        step(0, 0, 0, 0, 0, 5'h1f);
        step(0, 0, 0, 0, 1, 0);
        check("R10 lp set", lp_o, 1);
        for (int i = 0; i < 5; i++) ftick();
        check("R3 frozen in low-power", flags[3], 0);
        check("R8 no miss in low-power", flags[0], 0);

        // R4/R5 end of suspend with wake enabled
        wen = 1;
        step(1, 0, 0, 0, 0, 0);
        check("R5 wake with enable", last_wake, 1);
        check("R4 lp drops in same cycle", last_lp, 0);
        check("R4 end-suspend flag", flags[4], 1);
        check("R4 lp stays clear", lp_o, 0);

        // R3: resume wait then fresh count
        step(0, 0, 0, 0, 0, 5'h1f);
        ftick(); ftick();
        ftick(); ftick();
        check("R3 resume wait blocks check", flags[3], 0);
        ftick();
        check("R1 suspend after resume", flags[3], 1);

        // R5: no wake without enable
        wen = 0;
        step(0, 0, 0, 0, 1, 5'h1f);
        step(1, 0, 0, 0, 0, 0);
        check("R5 no wake without enable", last_wake, 0);
        check("R4 end-suspend flag again", flags[4], 1);

        // R6: bus reset cancels resume wait
        step(0, 0, 1, 0, 0, 5'h1f);
        ftick(); ftick();
        check("R6 early count", flags[3], 0);
        ftick();
        check("R6 resume cancelled by reset", flags[3], 1);
        idle(3);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule